// File: doc/BRIEF.md
# Value-to-Pixel Bar Column

This block turns an unsigned sample of configurable width into one column of pixels for a small monochrome panel. A typical use is one bar of a spectrum or equaliser view. The number of lit pixels is the value's share of full scale (all ones) times the column height, rounded to the nearest whole pixel. Lit pixels fill from the bottom of the column upward, so the column is a thermometer code.

The result is registered one clock after a valid input and comes with an output valid. The column is given bottom-first as a flat vector. An optional second output reorders the same column into 8-pixel bytes, for panels that are written one bank of eight rows at a time. Each pixel is decided by its own comparison against a constant threshold, so the path has no divider.

Top module: `pixbar_column`

## Requirements
- R1: After reset, `out_vld`, `col_o` and `bank_o` are all zero.
- R2: With FS = 2^VAL_W − 1, the lit count is floor((2·v·COL_H + FS) / (2·FS)), which is v·COL_H/FS rounded half up.
- R3: `col_o[i]` is the pixel i rows above the bottom. Exactly bits 0 through count−1 are set.
- R4: An input of 0 lights no pixel.
- R5: An input of FS lights all COL_H pixels.
- R6: With VAL_W=8 and COL_H=48, an input of 127 lights the lower half (24 pixels) and an input of 63 lights the lower quarter (12 pixels).
- R7: The outputs for a sample presented with `in_vld` high at a clock edge appear after that edge. `out_vld` is `in_vld` delayed by one clock.
- R8: While `in_vld` is low, `col_o` and `bank_o` keep their previous value and `in_val` has no effect.
- R9: With BANK_EN=1, byte k of `bank_o` (bits 8k+7..8k) holds display rows 8k..8k+7 counted from the top, with bit 0 at the top row of the bank. That is, `bank_o[8k+b] = col_o[COL_H−1−8k−b]`. COL_H must then be a multiple of 8.
- R10: With BANK_EN=0, `bank_o` is held at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 1 | Input sample valid |
| in_val | input | VAL_W | Unsigned input sample |
| out_vld | output | 1 | Output column valid, one clock after `in_vld` |
| col_o | output | COL_H | Pixel column, bit 0 at the bottom row |
| bank_o | output | COL_H | Column packed as COL_H/8 bank bytes, or zero when banking is off |

## Verification
The bench builds two instances.

The first uses the defaults: VAL_W=8, COL_H=48 and banking on. Every one of the 256 input codes is swept against the rounding rule, which covers the half and quarter points, both ends of the scale and the full byte layout of the six banks.

The second uses VAL_W=3, COL_H=16 and banking off. Its full scale of 7 does not divide the height evenly, so many codes fall near the half-pixel rounding boundary. This instance also shows that the bank output stays at zero when banking is disabled.

// File: rtl/pixbar_pkg.sv
package pixbar_pkg;

   // pixels carried by one display bank byte
   localparam int unsigned PB_BANK_W = 8;

   // width needed to hold 2*v*h + fs without overflow
   function automatic int unsigned pb_cmp_width(input int unsigned val_w,
                                                input int unsigned col_h);
      return val_w + $clog2(2 * col_h + 2);
   endfunction

   // number of banks in a column of the given height
   function automatic int unsigned pb_bank_count(input int unsigned col_h);
      return col_h / PB_BANK_W;
   endfunction

endpackage

// File: rtl/pixbar_thermo.sv
module pixbar_thermo
   import pixbar_pkg::*;
#(
   parameter int unsigned VAL_W = 8,
   parameter int unsigned COL_H = 48
) (
   input  logic [VAL_W-1:0] val_i,
   output logic [COL_H-1:0] therm_o
);

   localparam int unsigned CMP_W = pb_cmp_width(VAL_W, COL_H);
   localparam logic [VAL_W-1:0] FS = '1;
   localparam logic [CMP_W-1:0] FS_W = CMP_W'(FS);
   localparam logic [CMP_W-1:0] TWO_H = CMP_W'(2 * COL_H);

   // scaled numerator: 2*v*H + FS, shared by every pixel comparator
   logic [CMP_W-1:0] num;

   always_comb begin
      num = CMP_W'(val_i) * TWO_H + FS_W;
   end

   // pixel p (0 = bottom) is lit when the rounded count exceeds p,
   // i.e. num >= 2*(p+1)*FS
   for (genvar p = 0; p < COL_H; p++) begin : g_pix
      localparam logic [CMP_W-1:0] THR = CMP_W'(2 * (p + 1)) * FS_W;
      assign therm_o[p] = (num >= THR);
   end

endmodule

// File: rtl/pixbar_bank.sv
module pixbar_bank
   import pixbar_pkg::*;
#(
   parameter int unsigned COL_H   = 48,
   parameter bit          BANK_EN = 1'b1
) (
   input  logic [COL_H-1:0] col_i,
   output logic [COL_H-1:0] bank_o
);

   if (BANK_EN) begin : g_banked
      localparam int unsigned NBANK = pb_bank_count(COL_H);
      for (genvar k = 0; k < NBANK; k++) begin : g_bank
         for (genvar b = 0; b < PB_BANK_W; b++) begin : g_bit
            // row counted from the top sits at 8k+b; bottom-first index flips it
            assign bank_o[k*PB_BANK_W + b] = col_i[COL_H - 1 - k*PB_BANK_W - b];
         end
      end
   end else begin : g_flat
      assign bank_o = '0;
   end

endmodule

// File: rtl/pixbar_column.sv
module pixbar_column
   import pixbar_pkg::*;
#(
   parameter int unsigned VAL_W   = 8,
   parameter int unsigned COL_H   = 48,
   parameter bit          BANK_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic [VAL_W-1:0] in_val,
   output logic             out_vld,
   output logic [COL_H-1:0] col_o,
   output logic [COL_H-1:0] bank_o
);

   localparam logic [VAL_W-1:0] FS = '1;

   // elaboration-time parameter checks
   if (VAL_W < 1) begin : g_chk_w
      $error("pixbar_column: VAL_W must be at least 1");
   end
   if (COL_H < 1) begin : g_chk_h
      $error("pixbar_column: COL_H must be at least 1");
   end
   if (BANK_EN && (COL_H % PB_BANK_W != 0)) begin : g_chk_bank
      $error("pixbar_column: COL_H must be a multiple of 8 when banking");
   end

   logic [COL_H-1:0] therm;
   logic [COL_H-1:0] col_q;
   logic             vld_q;

   pixbar_thermo #(
      .VAL_W (VAL_W),
      .COL_H (COL_H)
   ) u_thermo (
      .val_i   (in_val),
      .therm_o (therm)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= in_vld;
         if (in_vld) begin
            col_q <= therm;
         end
      end
   end

   pixbar_bank #(
      .COL_H   (COL_H),
      .BANK_EN (BANK_EN)
   ) u_bank (
      .col_i  (col_q),
      .bank_o (bank_o)
   );

   assign col_o   = col_q;
   assign out_vld = vld_q;

   // R3
   thermo_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((col_q + COL_H'(1)) & col_q) == '0);

   // R4
   zero_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_val == '0) |=> (col_q == '0));

   // R5
   full_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_val == FS) |=> (&col_q));

   // R7
   vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld);

   // R7
   vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !out_vld);

   // R8
   col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> $stable(col_q));

   // R10
   bank_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!BANK_EN) |-> (bank_o == '0));

endmodule

// File: tb/pixbar_column_tb.sv
module pixbar_column_tb;

   localparam int unsigned W_A = 8;
   localparam int unsigned H_A = 48;
   localparam int unsigned W_B = 3;
   localparam int unsigned H_B = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;

   logic           vld_a = 1'b0;
   logic [W_A-1:0] val_a = '0;
   logic           ovld_a;
   logic [H_A-1:0] col_a, bank_a;

   logic           vld_b = 1'b0;
   logic [W_B-1:0] val_b = '0;
   logic           ovld_b;
   logic [H_B-1:0] col_b, bank_b;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pixbar_column #(.VAL_W(W_A), .COL_H(H_A), .BANK_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_vld(vld_a), .in_val(val_a),
      .out_vld(ovld_a), .col_o(col_a), .bank_o(bank_a));

   pixbar_column #(.VAL_W(W_B), .COL_H(H_B), .BANK_EN(1'b0)) u_dut_nb (
      .clk(clk), .rst_n(rst_n), .in_vld(vld_b), .in_val(val_b),
      .out_vld(ovld_b), .col_o(col_b), .bank_o(bank_b));

   function automatic int exp_cnt(input int v, input int w, input int h);
      int fs;
      fs = (1 << w) - 1;
      return (2 * v * h + fs) / (2 * fs);
   endfunction

   function automatic logic [63:0] exp_col(input int cnt);
      return (64'd1 << cnt) - 64'd1;
   endfunction

   function automatic logic [63:0] exp_bank(input int cnt, input int h);
      logic [63:0] r;
      r = '0;
      for (int i = 0; i < h; i++) r[i] = ((h - 1 - i) < cnt);
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic apply_a(input int v);
      @(negedge clk);
      val_a = W_A'(v);
      vld_a = 1'b1;
      @(negedge clk);
      vld_a = 1'b0;
   endtask

   task automatic apply_b(input int v);
      @(negedge clk);
      val_b = W_B'(v);
      vld_b = 1'b1;
      @(negedge clk);
      vld_b = 1'b0;
   endtask

   // R1
   task automatic t_reset();
      chk(ovld_a == 1'b0, "R1", "out_vld", 64'(ovld_a), 64'd0);
      chk(col_a == '0, "R1", "col", 64'(col_a), 64'd0);
      chk(bank_a == '0, "R1", "bank", 64'(bank_a), 64'd0);
      chk(col_b == '0, "R1", "col small", 64'(col_b), 64'd0);
   endtask

   // R6, R4, R5
   task automatic t_marks();
      apply_a(127);
      chk(col_a == H_A'(exp_col(24)), "R6", "127 half", 64'(col_a), exp_col(24));
      apply_a(63);
      chk(col_a == H_A'(exp_col(12)), "R6", "63 quarter", 64'(col_a), exp_col(12));
      apply_a(0);
      chk(col_a == '0, "R4", "zero", 64'(col_a), 64'd0);
      apply_a(255);
      chk(col_a == '1, "R5", "full", 64'(col_a), exp_col(H_A));
   endtask

   // R2, R3, R9: every code of the default instance
   task automatic t_sweep_a();
      for (int v = 0; v < (1 << W_A); v++) begin
         int c;
         c = exp_cnt(v, W_A, H_A);
         apply_a(v);
         chk(col_a == H_A'(exp_col(c)), "R2", $sformatf("col v=%0d", v),
             64'(col_a), exp_col(c));
         chk(bank_a == H_A'(exp_bank(c, H_A)), "R9", $sformatf("bank v=%0d", v),
             64'(bank_a), exp_bank(c, H_A));
      end
   endtask

   // R7, R8
   task automatic t_timing_hold();
      apply_a(200);
      chk(ovld_a == 1'b1, "R7", "valid after one clock", 64'(ovld_a), 64'd1);
      @(negedge clk);
      chk(ovld_a == 1'b0, "R7", "valid drops", 64'(ovld_a), 64'd0);
      val_a = 8'd5;
      @(negedge clk);
      @(negedge clk);
      chk(col_a == H_A'(exp_col(exp_cnt(200, W_A, H_A))), "R8", "hold col",
          64'(col_a), exp_col(exp_cnt(200, W_A, H_A)));
      chk(bank_a == H_A'(exp_bank(exp_cnt(200, W_A, H_A), H_A)), "R8", "hold bank",
          64'(bank_a), exp_bank(exp_cnt(200, W_A, H_A), H_A));
   endtask

   // R3 bank layout: a single lit row lands in the last byte, bit 7
   task automatic t_bank_edge();
      int v;
      v = 3; // 3*48/255 = 0.56 -> 1 pixel
      apply_a(v);
      chk(col_a == H_A'(1), "R3", "one bottom pixel", 64'(col_a), 64'd1);
      chk(bank_a == (H_A'(1) << (H_A - 1)), "R9", "bottom pixel in last bank",
          64'(bank_a), 64'd1 << (H_A - 1));
   endtask

   // R2, R10: small instance, rounding boundaries and no banking
   task automatic t_small();
      for (int v = 0; v < (1 << W_B); v++) begin
         int c;
         c = exp_cnt(v, W_B, H_B);
         apply_b(v);
         chk(col_b == H_B'(exp_col(c)), "R2", $sformatf("small col v=%0d", v),
             64'(col_b), exp_col(c));
         chk(bank_b == '0, "R10", "bank off", 64'(bank_b), 64'd0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_marks();
      t_sweep_a();
      t_timing_hold();
      t_bank_edge();
      t_small();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule